// File: doc/BRIEF.md
# Adaptive FSK Data Slicer

This block turns a stream of signed instantaneous-frequency samples from a digital FSK discriminator into hard bit decisions. The decision level is not assumed to be zero. The block follows the frequency as it swings up and down and records a peak each time the signal turns by more than a programmable expected deviation. The midpoint between the averaged high peaks and the averaged low peaks becomes the slicing threshold.

The threshold is also driven out as a signed value. The frequency-control logic downstream can use it as an estimate of the receiver-to-transmitter frequency offset. A two-bit settling mode sets how many recorded swings go into the averages. The all-zero mode turns adaptation off and slices at zero. A synchronous clear restarts the acquisition when the receive chain is re-enabled. The preamble should alternate 0 and 1 so that turns are recorded early.

Top module: `fsk_slicer`

## Requirements
- R1: For each accepted sample (`smp_vld` high, `clr` low), `bit_vld` is high in the next cycle and `bit_out` is 1 exactly when the signed sample is strictly greater than the `thr` value present in the sample's own cycle. In any other cycle `bit_vld` goes low in the next cycle and `bit_out` holds its value.
- R2: The expected deviation is (16 + `dev_man`) shifted left by `dev_exp`, in sample units. A turn is recorded only when the swing from the tracked peak to the new sample is strictly greater than this deviation. A swing equal to it records nothing.
- R3: After a clear, the first accepted sample becomes the tracked peak in low-seeking state. While low-seeking, lower samples replace the peak, and a rise past the deviation records the peak as a low extreme and switches to high-seeking with the new sample as peak. High-seeking mirrors this with higher samples and falls.
- R4: `thr_valid` is high exactly when `settle` is nonzero and at least 3 turns have been recorded since reset or clear.
- R5: While `thr_valid` is high, `thr` equals floor((mean_high + mean_low) / 2). While it is low, `thr` is 0.
- R6: The first recorded extreme of each polarity loads that polarity's mean directly. Each later one updates it as mean + floor((extreme - mean) / 2^k), with k = 0, 2, 3 for `settle` = 01, 10, 11. This gives windows of about 2, 8 and 16 turns.
- R7: With `settle` = 00, `thr` is 0 and `thr_valid` is low. Peak tracking and averaging still run, so a later nonzero `settle` uses the state built up meanwhile.
- R8: `clr` clears the tracker, the means and the turn count. A sample presented in the same cycle is dropped, and `bit_vld` is low in the next cycle.
- R9: During and straight after reset, `bit_out`, `bit_vld` and `thr_valid` are 0 and `thr` is 0.
- R10: With no accepted sample and `settle` unchanged, `thr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of the acquisition |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SMP_W | Signed frequency sample |
| dev_exp | input | EXP_W | Expected-deviation exponent |
| dev_man | input | MAN_W | Expected-deviation mantissa |
| settle | input | 2 | Averaging mode, 00 = adaptation off |
| bit_out | output | 1 | Registered hard decision |
| bit_vld | output | 1 | Decision strobe |
| thr_valid | output | 1 | Threshold acquired |
| thr | output | SMP_W | Signed threshold / frequency-offset estimate |

## Verification
The bound checker checks the cycle-level contract on every cycle. It covers the strobe timing of `bit_vld`, the decision against the previous cycle's threshold, the hold of `bit_out` and `thr` when no sample is accepted, the effect of `clr` on the valid flag, and the forcing of `thr_valid` low when adaptation is off. Whether the right peaks are recorded, whether the deviation boundary is strict, and whether the running means converge to the right values can only be shown by the bench. It runs a reference model over directed swing patterns and over random offset FSK waveforms in each settling mode.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [1:0] {
    SET_OFF  = 2'b00,
    SET_FAST = 2'b01,
    SET_MID  = 2'b10,
    SET_SLOW = 2'b11
  } settle_e;

  // Mean update weight 1/2^k for each settling mode
  function automatic logic [1:0] mean_shift(input settle_e m);
    case (m)
      SET_MID:  mean_shift = 2'd2;
      SET_SLOW: mean_shift = 2'd3;
      default:  mean_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/slc_dev_calc.sv
module slc_dev_calc #(
  parameter int EXP_W = 2,
  parameter int MAN_W = 4,
  parameter int DEV_W = MAN_W + 1 + (2**EXP_W - 1)
) (
  input  logic [EXP_W-1:0] dev_exp,
  input  logic [MAN_W-1:0] dev_man,
  output logic [DEV_W-1:0] dev
);
  localparam int PAD_W = DEV_W - MAN_W - 1;

  logic [DEV_W-1:0] base;

  always_comb begin
    base = {{PAD_W{1'b0}}, 1'b1, dev_man};
    dev  = base << dev_exp;
  end
endmodule

// File: rtl/slc_peak_track.sv
module slc_peak_track #(
  parameter int SMP_W = 12,
  parameter int DEV_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [DEV_W-1:0]        dev,
  output logic                    ev,
  output logic                    ev_hi,
  output logic signed [SMP_W-1:0] ev_val
);
  localparam int EXT_W = SMP_W + 1;

  logic                    started_q, started_d;
  logic                    hi_q, hi_d;
  logic signed [SMP_W-1:0] pk_q, pk_d;
  logic signed [EXT_W-1:0] rise, fall, dev_s;
  logic                    upd;

  always_comb begin
    dev_s = $signed({{(EXT_W-DEV_W){1'b0}}, dev});
    rise  = {smp[SMP_W-1], smp} - {pk_q[SMP_W-1], pk_q};
    fall  = {pk_q[SMP_W-1], pk_q} - {smp[SMP_W-1], smp};
  end

  always_comb begin
    started_d = started_q;
    hi_d      = hi_q;
    pk_d      = pk_q;
    ev        = 1'b0;
    ev_hi     = hi_q;
    ev_val    = pk_q;
    if (clr) begin
      started_d = 1'b0;
      hi_d      = 1'b0;
      pk_d      = '0;
    end else if (en) begin
      if (!started_q) begin
        started_d = 1'b1;
        hi_d      = 1'b0;
        pk_d      = smp;
      end else if (hi_q) begin
        if (smp > pk_q) begin
          pk_d = smp;
        end else if (fall > dev_s) begin
          ev   = 1'b1;
          hi_d = 1'b0;
          pk_d = smp;
        end
      end else begin
        if (smp < pk_q) begin
          pk_d = smp;
        end else if (rise > dev_s) begin
          ev   = 1'b1;
          hi_d = 1'b1;
          pk_d = smp;
        end
      end
    end
  end

  assign upd = clr | en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      hi_q      <= 1'b0;
      pk_q      <= '0;
    end else if (upd) begin
      started_q <= started_d;
      hi_q      <= hi_d;
      pk_q      <= pk_d;
    end
  end
endmodule

// File: rtl/slc_run_mean.sv
module slc_run_mean #(
  parameter int SMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    upd,
  input  logic [1:0]              sh,
  input  logic signed [SMP_W-1:0] val,
  output logic signed [SMP_W-1:0] mean
);
  localparam int EXT_W = SMP_W + 1;

  logic                    has_q, has_d;
  logic signed [SMP_W-1:0] mean_q, mean_d;
  logic signed [EXT_W-1:0] diff, step, sum;
  logic                    en;

  always_comb begin
    diff   = {val[SMP_W-1], val} - {mean_q[SMP_W-1], mean_q};
    step   = diff >>> sh;
    sum    = {mean_q[SMP_W-1], mean_q} + step;
    has_d  = has_q;
    mean_d = mean_q;
    if (clr) begin
      has_d  = 1'b0;
      mean_d = '0;
    end else if (upd) begin
      has_d  = 1'b1;
      mean_d = has_q ? sum[SMP_W-1:0] : val;
    end
  end

  assign en = clr | upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_q  <= 1'b0;
      mean_q <= '0;
    end else if (en) begin
      has_q  <= has_d;
      mean_q <= mean_d;
    end
  end

  assign mean = mean_q;
endmodule

// File: rtl/fsk_slicer.sv
module fsk_slicer
  import slc_pkg::*;
#(
  parameter int SMP_W     = 12,
  parameter int EXP_W     = 2,
  parameter int MAN_W     = 4,
  parameter int MIN_TRANS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [EXP_W-1:0]        dev_exp,
  input  logic [MAN_W-1:0]        dev_man,
  input  logic [1:0]              settle,
  output logic                    bit_out,
  output logic                    bit_vld,
  output logic                    thr_valid,
  output logic signed [SMP_W-1:0] thr
);
  localparam int DEV_W = MAN_W + 1 + (2**EXP_W - 1);
  localparam int CNT_W = $clog2(MIN_TRANS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_TRANS);

  logic [DEV_W-1:0]        dev;
  logic                    take;
  logic                    ev, ev_hi;
  logic signed [SMP_W-1:0] ev_val;
  logic signed [SMP_W-1:0] mean [2];
  logic [1:0]              sh;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [SMP_W:0]   mid_sum;
  logic                    bit_d;

  assign take = smp_vld & ~clr;
  assign sh   = mean_shift(settle_e'(settle));

  slc_dev_calc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DEV_W(DEV_W)) u_dev (
    .dev_exp (dev_exp),
    .dev_man (dev_man),
    .dev     (dev)
  );

  slc_peak_track #(.SMP_W(SMP_W), .DEV_W(DEV_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (smp_vld),
    .smp    (smp),
    .dev    (dev),
    .ev     (ev),
    .ev_hi  (ev_hi),
    .ev_val (ev_val)
  );

  // Index 0 averages the low extremes, index 1 the high extremes
  for (genvar g = 0; g < 2; g++) begin : g_mean
    logic upd_g;
    assign upd_g = ev & (ev_hi == (g == 1));
    slc_run_mean #(.SMP_W(SMP_W)) u_mean (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .upd   (upd_g),
      .sh    (sh),
      .val   (ev_val),
      .mean  (mean[g])
    );
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (ev && cnt_q < CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr | ev) cnt_q <= cnt_d;
  end

  always_comb begin
    mid_sum   = {mean[1][SMP_W-1], mean[1]} + {mean[0][SMP_W-1], mean[0]};
    thr_valid = (settle != SET_OFF) && (cnt_q >= CNT_MAX);
    thr       = thr_valid ? mid_sum[SMP_W:1] : '0;
    bit_d     = smp > thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_vld <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      bit_vld <= take;
      if (take) bit_out <= bit_d;
    end
  end
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int SMP_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    smp_vld,
  input logic signed [SMP_W-1:0] smp,
  input logic [1:0]              settle,
  input logic                    bit_out,
  input logic                    bit_vld,
  input logic                    thr_valid,
  input logic signed [SMP_W-1:0] thr
);
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !clr) |=> bit_vld);

  p_decide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !clr) |=> (bit_out == ($past(smp) > $past(thr))));

  p_hold_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && !clr) |=> $stable(bit_out));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld || clr) |=> !bit_vld);

  p_clr_novalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !thr_valid);

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 2'b00) |-> !thr_valid);

  p_hold_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !clr) |=> ($stable(thr) || !$stable(settle)));
endmodule

bind fsk_slicer slc_checker #(.SMP_W(SMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .smp_vld   (smp_vld),
  .smp       (smp),
  .settle    (settle),
  .bit_out   (bit_out),
  .bit_vld   (bit_vld),
  .thr_valid (thr_valid),
  .thr       (thr)
);

// File: tb/sim_fsk_slicer.sv
`timescale 1ns/1ps
module sim_fsk_slicer;
  localparam int W = 12;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                clr;
  logic                smp_vld;
  logic signed [W-1:0] smp;
  logic [1:0]          dev_exp;
  logic [3:0]          dev_man;
  logic [1:0]          settle;
  logic                bit_out, bit_vld, thr_valid;
  logic signed [W-1:0] thr;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_st, m_hi;
  int m_pk, m_cnt;
  int m_avg[2];
  bit m_has[2];

  always #2 clk = ~clk;

  fsk_slicer u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .smp(smp),
    .dev_exp(dev_exp), .dev_man(dev_man), .settle(settle),
    .bit_out(bit_out), .bit_vld(bit_vld), .thr_valid(thr_valid), .thr(thr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dev_val();
    return (16 + int'(dev_man)) << dev_exp;
  endfunction

  function automatic bit m_valid();
    return (settle != 2'b00) && (m_cnt >= 3);
  endfunction

  function automatic int m_thr();
    return m_valid() ? ((m_avg[1] + m_avg[0]) >>> 1) : 0;
  endfunction

  function automatic int shift_of();
    case (settle)
      2'b10:   return 2;
      2'b11:   return 3;
      default: return 0;
    endcase
  endfunction

  task automatic m_clear();
    m_st = 0; m_hi = 0; m_pk = 0; m_cnt = 0;
    for (int g = 0; g < 2; g++) begin m_avg[g] = 0; m_has[g] = 0; end
  endtask

  task automatic m_record(input int g, input int v);
    if (!m_has[g]) begin m_avg[g] = v; m_has[g] = 1; end
    else m_avg[g] = m_avg[g] + ((v - m_avg[g]) >>> shift_of());
    if (m_cnt < 3) m_cnt++;
  endtask

  task automatic m_sample(input int x);
    int d;
    d = dev_val();
    if (!m_st) begin m_st = 1; m_hi = 0; m_pk = x; end
    else if (m_hi) begin
      if (x > m_pk) m_pk = x;
      else if (m_pk - x > d) begin m_record(1, m_pk); m_hi = 0; m_pk = x; end
    end else begin
      if (x < m_pk) m_pk = x;
      else if (x - m_pk > d) begin m_record(0, m_pk); m_hi = 1; m_pk = x; end
    end
  endtask

  // One cycle: drive at negedge, check at the following negedge
  task automatic step(input bit v, input int x, input bit c);
    bit e_vld, e_bit;
    e_vld = v && !c;
    e_bit = x > m_thr();
    smp_vld = v; smp = W'(x); clr = c;
    if (c) m_clear();
    else if (v) m_sample(x);
    @(posedge clk);
    @(negedge clk);
    chk(bit_vld == e_vld, "R1/R8 bit_vld", int'(bit_vld), int'(e_vld));
    if (e_vld) chk(bit_out == e_bit, "R1 bit_out", int'(bit_out), int'(e_bit));
    chk(thr_valid == m_valid(), "R4 thr_valid", int'(thr_valid), int'(m_valid()));
    chk(int'(thr) == m_thr(), "R5/R6 thr", int'(thr), m_thr());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lvl, x, off, amp, run;
    void'($urandom(32'd20240611));
    rst_n = 0; clr = 0; smp_vld = 0; smp = '0;
    dev_exp = 0; dev_man = 0; settle = 2'b01;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bit_vld && !bit_out && !thr_valid && thr == 0, "R9 reset", int'(thr), 0);
    rst_n = 1;
    @(negedge clk);

    // R3/R4/R5: 100,200,100,200 gives three turns and threshold 150
    step(1, 100, 0); step(1, 200, 0); step(1, 100, 0);
    chk(!thr_valid, "R4 two turns", int'(thr_valid), 0);
    step(1, 200, 0);
    chk(thr_valid && thr == 150, "R5 midpoint", int'(thr), 150);

    // R8: clear with a sample present drops it
    step(1, 500, 1);
    chk(!thr_valid && !bit_vld, "R8 clear", int'(thr_valid), 0);

    // R2: swing equal to deviation (16) is not a turn
    for (int i = 0; i < 3; i++) begin step(1, 0, 0); step(1, 16, 0); end
    chk(!thr_valid, "R2 equal swing", int'(thr_valid), 0);
    step(1, 0, 1);
    step(1, 0, 0); step(1, 17, 0); step(1, 0, 0); step(1, 17, 0);
    chk(thr_valid && thr == 8, "R2 swing above", int'(thr), 8);

    // R1: strict comparison at the threshold
    step(1, 8, 0);
    chk(bit_out == 1'b0, "R1 equal to thr", int'(bit_out), 0);
    step(1, 9, 0);
    chk(bit_out == 1'b1, "R1 above thr", int'(bit_out), 1);

    // R7: adaptation off, state kept
    settle = 2'b00;
    step(1, -40, 0); step(1, 60, 0);
    chk(thr == 0 && !thr_valid, "R7 off", int'(thr), 0);
    settle = 2'b01;
    step(0, 0, 0);
    chk(thr_valid, "R7 resume", int'(thr_valid), 1);

    // R10: idle cycles keep threshold
    for (int i = 0; i < 4; i++) step(0, 0, 0);

    // R6 and general: random offset FSK in each mode
    for (int mode = 1; mode <= 3; mode++) begin
      for (int blk = 0; blk < 4; blk++) begin
        settle  = 2'(mode);
        dev_man = 4'($urandom_range(0, 15));
        dev_exp = 2'($urandom_range(0, 3));
        off = int'($urandom_range(0, 800)) - 400;
        amp = int'($urandom_range(300, 700));
        lvl = 0;
        step(1, 0, 1);
        for (int s = 0; s < 150; s++) begin
          run = int'($urandom_range(1, 4));
          lvl = ~lvl & 1;
          for (int r = 0; r < run; r++) begin
            x = off + (lvl != 0 ? amp : -amp) + int'($urandom_range(0, 60)) - 30;
            if (x > 2047) x = 2047;
            if (x < -2048) x = -2048;
            step($urandom_range(0, 9) != 0, x, $urandom_range(0, 499) == 0);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule